// File: doc/BRIEF.md
# Prioritized Interrupt Pending Controller

This block gathers interrupt requests from up to four plug-in modules, each with two request lines, for eight sources in all. Every request input is synchronized and its rising edge latches a pending bit. A per-source enable masks the pending bits, and an external global enable gates the combined result onto a single host request line. That line carries a host interrupt level which is programmed outside the block.

A fixed priority encoder reports which enabled pending source the host should serve next. The lowest bit index wins. The host reaches the block through a byte-wide register port with three registers: an enable register (read/write), a pending register (read-only) and a write-one-to-clear register. A build parameter can limit the block to two modules. In that case the upper four sources are removed.

Top module: `irq_pend_ctrl`

## Requirements
- R1: After reset the enable and pending registers read 0x00, irq_o is 0, irq_lvl_o is 0 and ack_vld_o is 0.
- R2: The enable register sits at offset 0xE1 and is read/write. Bit n set to 1 enables source n.
- R3: The pending register sits at offset 0xE3 and is read-only. Bit n is set one cycle after a rising edge of the synchronized req_i[n] (two synchronizer stages), whether or not source n is enabled. A level held high sets the bit only once.
- R4: Writing a byte to offset 0xE5 clears every pending bit that has a 1 in that byte. Bits written as 0 are left unchanged. Reading 0xE5 returns 0x00 and has no effect.
- R5: If a bit is set and cleared in the same cycle, the set wins and the bit stays pending.
- R6: irq_o is 1 exactly when glb_en_i is 1 and some source is both pending and enabled.
- R7: irq_lvl_o equals lvl_i while irq_o is 1 and is 0 otherwise.
- R8: When any source is both pending and enabled, ack_vld_o is 1 and ack_idx_o is the lowest such index (bit 0 has the highest priority). Otherwise ack_vld_o is 0. Neither output depends on glb_en_i.
- R9: With NUM_MOD=2, bits 4..7 of the enable and pending registers read 0, ignore writes and never become pending.
- R10: Reads of any other offset return 0x00. Writes to any other offset, and writes to the pending register, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 8 | Asynchronous module request lines; bit 2m+k is module m, line k |
| glb_en_i | input | 1 | Global interrupt enable |
| lvl_i | input | 3 | Programmed host interrupt level |
| addr_i | input | 8 | Register offset |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from addr_i while rd_i is high, else 0 |
| irq_o | output | 1 | Host interrupt request |
| irq_lvl_o | output | 3 | Level presented with the request |
| ack_idx_o | output | 3 | Index of the winning source |
| ack_vld_o | output | 1 | A winning source exists |

## Verification
The enable register is swept through all 256 values and read back. The priority path is driven with all 256 request patterns, each under two different enable masks. This separates "lowest enabled pending bit" from both "lowest pending bit" and "lowest enabled bit". Single-bit requests sent with the enable off show that pending is visible without the enable and that the request line stays quiet. The global enable and level outputs are toggled on a fixed pending set. A cycle-aligned clear during a set, a clear while the request is held high, a partial clear, and writes to the pending register and to a stray offset separate the edge-capture, set-priority and write-decode behaviours. A second instance built with two modules is checked for masking of the upper four bits.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 8;
  localparam int IDX_W  = $clog2(DATA_W);
  localparam logic [ADDR_W-1:0] OFS_EN  = 8'hE1;
  localparam logic [ADDR_W-1:0] OFS_PND = 8'hE3;
  localparam logic [ADDR_W-1:0] OFS_CLR = 8'hE5;
endpackage

// File: rtl/irq_sync_edge.sv
module irq_sync_edge #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= '0;
    else         stg_q[0] <= async_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else         stg_q[s] <= stg_q[s-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= stg_q[STAGES-1];
  end

  assign rise_o = stg_q[STAGES-1] & ~prev_q;

  // R3
  single_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_o & $past(rise_o)) == '0);
endmodule

// File: rtl/irq_pend_regs.sv
module irq_pend_regs #(
  parameter int                          W    = 8,
  parameter logic [irq_pkg::DATA_W-1:0] MASK = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         en_we_i,
  input  logic [W-1:0] en_wd_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] en_o,
  output logic [W-1:0] pend_o
);
  logic [W-1:0] en_q, pend_q;
  localparam logic [W-1:0] VMASK = MASK[W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_q <= '0;
    else if (en_we_i) en_q <= en_wd_i & VMASK;
  end

  // set beats clear so no event is lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= ((pend_q & ~clr_i) | set_i) & VMASK;
  end

  assign en_o   = en_q;
  assign pend_o = pend_q;

  // R3
  pend_set_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q & ~$past(pend_q) & ~$past(set_i)) == '0);
  // R4
  pend_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q & $past(clr_i & ~set_i)) == '0);
  // R5
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(set_i & VMASK) & ~pend_q) == '0);
  // R9
  unused_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend_q | en_q) & ~VMASK) == '0);
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int W     = 8,
  parameter int IDX_W = 3
) (
  input  logic [W-1:0]     vec_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             vld_o
);
  always_comb begin
    idx_o = '0;
    for (int i = W-1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IDX_W'(i);
    end
  end
  assign vld_o = |vec_i;
endmodule

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl
  import irq_pkg::*;
#(
  parameter int NUM_MOD     = 4,
  parameter int REQ_PER_MOD = 2,
  parameter int SYNC_STAGES = 2,
  parameter int LVL_W       = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] req_i,
  input  logic              glb_en_i,
  input  logic [LVL_W-1:0]  lvl_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic [LVL_W-1:0]  irq_lvl_o,
  output logic [IDX_W-1:0]  ack_idx_o,
  output logic              ack_vld_o
);
  localparam int NUM_SRC = NUM_MOD * REQ_PER_MOD;
  localparam logic [DATA_W-1:0] VMASK =
    (NUM_SRC >= DATA_W) ? '1 : DATA_W'((1 << NUM_SRC) - 1);

  logic [DATA_W-1:0] rise, en, pend, act, clr;
  logic              en_we;

  irq_sync_edge #(.W(DATA_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .async_i(req_i & VMASK), .rise_o(rise)
  );

  assign en_we = wr_i && (addr_i == OFS_EN);
  assign clr   = (wr_i && (addr_i == OFS_CLR)) ? wdata_i : '0;

  irq_pend_regs #(.W(DATA_W), .MASK(VMASK)) u_regs (
    .clk_i, .rst_ni, .set_i(rise), .en_we_i(en_we), .en_wd_i(wdata_i),
    .clr_i(clr), .en_o(en), .pend_o(pend)
  );

  assign act = pend & en;

  irq_prio_enc #(.W(DATA_W), .IDX_W(IDX_W)) u_prio (
    .vec_i(act), .idx_o(ack_idx_o), .vld_o(ack_vld_o)
  );

  assign irq_o     = glb_en_i & ack_vld_o;
  assign irq_lvl_o = irq_o ? lvl_i : '0;

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      unique case (addr_i)
        OFS_EN:  rdata_o = en;
        OFS_PND: rdata_o = pend;
        default: rdata_o = '0;
      endcase
    end
  end

  // R6
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (glb_en_i && (pend & en) != '0));
  // R8
  ack_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_vld_o |-> (pend[ack_idx_o] && en[ack_idx_o]));
  // R8
  ack_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_vld_o |-> ((pend & en & ((DATA_W'(1) << ack_idx_o) - DATA_W'(1))) == '0));
  // R7
  lvl_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> (irq_lvl_o == '0));
endmodule

// File: tb/irq_pend_ctrl_tb_top.sv
module irq_pend_ctrl_tb_top;
  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic [7:0] req = 0, req2 = 0, addr = 0, wd = 0, rdat, rdat2;
  logic rd = 0, wr = 0, glb = 0;
  logic [2:0] lvl = 3'd5, irq_lvl, aidx, irq_lvl2, aidx2;
  logic irq, avld, irq2, avld2;
  int total = 0, bad = 0;

  irq_pend_ctrl dut_i (.clk_i(clk), .rst_ni(rst_n), .req_i(req), .glb_en_i(glb),
    .lvl_i(lvl), .addr_i(addr), .rd_i(rd), .wr_i(wr), .wdata_i(wd), .rdata_o(rdat),
    .irq_o(irq), .irq_lvl_o(irq_lvl), .ack_idx_o(aidx), .ack_vld_o(avld));

  irq_pend_ctrl #(.NUM_MOD(2)) dut2_i (.clk_i(clk), .rst_ni(rst_n), .req_i(req2),
    .glb_en_i(glb), .lvl_i(lvl), .addr_i(addr), .rd_i(rd), .wr_i(wr), .wdata_i(wd),
    .rdata_o(rdat2), .irq_o(irq2), .irq_lvl_o(irq_lvl2), .ack_idx_o(aidx2),
    .ack_vld_o(avld2));

  task automatic chk(string r, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", r, act, exp);
    end
  endtask

  task automatic wreg(logic [7:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wd = d; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic rreg(logic [7:0] a, output logic [7:0] d, output logic [7:0] d2);
    @(negedge clk); addr = a; rd = 1; #1; d = rdat; d2 = rdat2; rd = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int low_idx(logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 0;
  endfunction

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog act=hang exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v, v2;
    idle(2); rst_n = 1; idle(1);
    // R1 reset state
    rreg(8'hE1, v, v2); chk("R1 en", v, 0);
    rreg(8'hE3, v, v2); chk("R1 pend", v, 0);
    chk("R1 irq", {irq, irq_lvl, avld}, 0);

    // R2 enable sweep
    for (int e = 0; e < 256; e++) begin
      wreg(8'hE1, 8'(e)); rreg(8'hE1, v, v2);
      chk("R2 en rw", v, e);
      chk("R9 en mask", v2, e & 8'h0f);
    end

    // R3 pending visible with enables off, no request out
    wreg(8'hE1, 8'h00); glb = 1;
    for (int b = 0; b < 8; b++) begin
      req = 8'(1 << b); idle(4);
      rreg(8'hE3, v, v2); chk("R3 pend w/o en", v, 1 << b);
      chk("R6 no irq when disabled", irq, 0);
      req = 0; wreg(8'hE5, 8'hff); idle(1);
    end

    // R8/R6 priority sweep under two masks
    for (int p = 0; p < 256; p++) begin
      for (int m = 0; m < 2; m++) begin
        logic [7:0] en;
        en = (m == 0) ? 8'hff : {p[2:0], p[7:3]} ^ 8'h5a;
        wreg(8'hE1, en);
        req = 8'(p); idle(4);
        #1;
        chk("R8 vld", avld, ((p & en) != 0));
        if ((p & en) != 0) chk("R8 idx", aidx, low_idx(8'(p) & en));
        chk("R6 irq", irq, ((p & en) != 0));
        rreg(8'hE3, v, v2); chk("R3 pend pat", v, p);
        req = 0; wreg(8'hE5, 8'hff); idle(1);
      end
    end

    // R6/R7/R8 global gate and level
    wreg(8'hE1, 8'h30); req = 8'h30; idle(4);
    glb = 0; #1;
    chk("R6 glb off", irq, 0); chk("R7 lvl zero", irq_lvl, 0);
    chk("R8 ack w/o glb", {avld, aidx}, {1'b1, 3'd4});
    glb = 1; lvl = 3'd6; #1;
    chk("R6 glb on", irq, 1); chk("R7 lvl", irq_lvl, 6);
    // R4 partial clear and clear while held high
    wreg(8'hE5, 8'h10); rreg(8'hE3, v, v2); chk("R4 partial clr", v, 8'h20);
    idle(3); rreg(8'hE3, v, v2); chk("R3 held no reset", v, 8'h20);
    rreg(8'hE5, v, v2); chk("R4 clr reads 0", v, 0);
    rreg(8'hE3, v, v2); chk("R4 read no effect", v, 8'h20);
    // R10 pending write and stray offsets
    wreg(8'hE3, 8'h00); rreg(8'hE3, v, v2); chk("R10 pend ro", v, 8'h20);
    wreg(8'hE0, 8'hff); rreg(8'hE1, v, v2); chk("R10 stray wr", v, 8'h30);
    rreg(8'hE0, v, v2); chk("R10 stray rd", v, 0);
    rreg(8'hE2, v, v2); chk("R10 stray rd2", v, 0);
    req = 0; wreg(8'hE5, 8'hff); idle(1);

    // R5 set and clear in same cycle
    @(negedge clk); req = 8'h04;
    @(negedge clk); @(negedge clk); addr = 8'hE5; wd = 8'h04; wr = 1;
    @(negedge clk); wr = 0;
    rreg(8'hE3, v, v2); chk("R5 set wins", v, 8'h04);
    req = 0; wreg(8'hE5, 8'hff); idle(1);

    // R9 two-module build
    wreg(8'hE1, 8'hff); req2 = 8'hff; idle(4);
    rreg(8'hE3, v, v2); chk("R9 pend mask", v2, 8'h0f);
    req2 = 8'hf0; wreg(8'hE5, 8'hff); idle(1); req2 = 0; idle(1); req2 = 8'hf0; idle(4);
    rreg(8'hE3, v, v2); chk("R9 upper never pend", v2, 0);
    chk("R9 no irq", irq2, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule